// File: doc/BRIEF.md
# Buffered Multi-Length Serial Transmitter

This block is the transmit half of a synchronous serial port. A host places a frame into up to four byte-wide holding lanes through a small register port. A 2-bit length code decides how many lanes form the frame: one lane for 8 bits, two lanes for 16 bits, or four lanes for 32 bits. The fourth code is reserved.

Once the highest lane in use is written, the buffer counts as full. As soon as the shift register is free, the frame moves into it and is clocked out, most significant bit first, on `sdo_o`. A serial clock `sclk_o` is derived from the system clock and runs alongside it. If the host refills the buffer while a frame is still going out, the next frame follows with no gap. Two flags guide the host. `tde_o` says the buffer may be written, and `tend_o` says the line has gone quiet with nothing pending.

Top module: `ser_tx_buf`

## Requirements
- R1: After reset, every lane reads 0, `tde_o`=1, `tend_o`=1, `cfg_err_o`=0, `sclk_o`=0 and `sdo_o`=0.
- R2: `len_i` selects the valid lanes. 2'b00 means lane 0 only (8 bits). 2'b01 means lanes 0–1 (16 bits). 2'b10 means lanes 0–3 (32 bits). 2'b11 is reserved. `addr_i` selects lane 0..3.
- R3: A valid lane takes `wdata_i` on a write and returns its content on `rdata_o` (combinational on `addr_i`). A write to a lane that is not valid for the current code is ignored, and a read of such a lane returns 0.
- R4: `tde_o` clears in the cycle after a write to the highest valid lane. A write to a lower lane leaves it unchanged.
- R5: When the buffer is full and the shifter is idle, the next clock copies the frame into the shifter and sets `tde_o` to 1.
- R6: Bits leave MSB first. The highest valid lane is the most significant byte, and lane 0 is the least significant byte.
- R7: `sclk_o` is low when idle. Its period is 2·N system clocks, where N is `div_i`. A `div_i` of 0 acts as 1.
- R8: `sdo_o` changes only as `sclk_o` falls, or at the start of a frame while it is low. It is stable while `sclk_o` is high, so the receiver samples on the rising edge.
- R9: A frame buffered before the current frame ends starts at that frame's last falling edge. The spacing of rising edges stays exactly 2·N across the boundary.
- R10: `tend_o` sets when the last bit of a frame has been shifted and the buffer is empty. It clears on any accepted lane write.
- R11: With code 2'b11, no frame starts, all writes are ignored, and `cfg_err_o` is 1 from the cycle after the code is applied until the cycle after it changes. Lane contents survive a stay in the reserved code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Lane write strobe |
| addr_i | input | 2 | Lane select for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of selected lane |
| len_i | input | 2 | Frame length code |
| div_i | input | 8 | Serial clock half-period in system clocks |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |
| tde_o | output | 1 | Buffer may be written |
| tend_o | output | 1 | Transmission ended, buffer empty |
| cfg_err_o | output | 1 | Reserved length code in use |

## Verification
Single frames are sent at each of the three lengths, using asymmetric data words. These words show whether the lane order or the bit order is reversed, and whether too few or too many bits are sent. A pair of 16-bit frames is written so the second one is queued during the first. This separates a true back-to-back restart from one that adds an idle half-period. It also shows whether the second frame overwrote the first. Divider values 3, 2 and 0 are used to tell correct 2·N pacing apart from an off-by-one count or a stalled zero setting. A write made under the reserved code, followed by a return to a valid code, shows whether the write reached storage and whether a frame started anyway.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int NLANES = 4;

  typedef enum logic [1:0] {
    LEN_B8   = 2'b00,
    LEN_B16  = 2'b01,
    LEN_B32  = 2'b10,
    LEN_RSVD = 2'b11
  } len_e;

  // number of active lanes for a length code, 0 when reserved
  function automatic logic [2:0] lanes_of(input logic [1:0] code);
    case (len_e'(code))
      LEN_B8:  return 3'd1;
      LEN_B16: return 3'd2;
      LEN_B32: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ser_tx_lanes.sv
module ser_tx_lanes #(
  parameter  int LANE_W = 8,
  parameter  int NLANES = 4,
  localparam int WORD_W = LANE_W * NLANES,
  localparam int AW     = $clog2(NLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic [2:0]        n_lanes_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_ok_o,
  output logic              hi_wr_o
);
  logic [LANE_W-1:0] lane_q [NLANES];
  logic [WORD_W-1:0] full_w;
  logic              addr_ok;

  assign addr_ok = int'(addr_i) < int'(n_lanes_i);
  assign wr_ok_o = wr_en_i && addr_ok;
  assign hi_wr_o = wr_ok_o && (int'(addr_i) == int'(n_lanes_i) - 1);
  assign rdata_o = addr_ok ? lane_q[addr_i] : '0;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      lane_q[g] <= '0;
      else if (wr_ok_o && int'(addr_i) == g)            lane_q[g] <= wdata_i;
    end
    assign full_w[g*LANE_W +: LANE_W] = lane_q[g];
  end

  // left-align so the highest valid lane lands in the MSBs
  always_comb begin
    word_o = '0;
    if (n_lanes_i != 3'd0)
      word_o = full_w << ((NLANES - int'(n_lanes_i)) * LANE_W);
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter  int WORD_W = 32,
  parameter  int DIV_W  = 8,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [DIV_W-1:0]  half_i,
  output logic              busy_o,
  output logic              frame_end_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic [DIV_W-1:0]  cnt_q, half_eff;
  logic              busy_q, sclk_q, tick;

  assign half_eff    = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick        = cnt_q == half_eff - DIV_W'(1);
  assign frame_end_o = busy_q && tick && sclk_q && (left_q == CNT_W'(1));
  assign busy_o      = busy_q;
  assign sclk_o      = sclk_q;
  assign sdo_o       = busy_q && sh_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= nbits_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
          end else begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - CNT_W'(1);
          end
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ser_tx_buf.sv
module ser_tx_buf #(
  parameter  int LANE_W = 8,
  parameter  int DIV_W  = 8,
  localparam int NLANES = ser_tx_pkg::NLANES,
  localparam int WORD_W = LANE_W * NLANES,
  localparam int AW     = $clog2(NLANES),
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o,
  input  logic [1:0]        len_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              tde_o,
  output logic              tend_o,
  output logic              cfg_err_o
);
  logic [2:0]        n_lanes;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  nbits;
  logic              wr_ok, hi_wr, busy, frame_end, load;
  logic              tde_q, tend_q, cfg_err_q;

  assign n_lanes = ser_tx_pkg::lanes_of(len_i);
  assign nbits   = CNT_W'(int'(n_lanes) * LANE_W);
  // reload on the closing falling edge keeps frames gapless
  assign load    = (n_lanes != 3'd0) && !tde_q && (!busy || frame_end);

  ser_tx_lanes #(.LANE_W(LANE_W), .NLANES(NLANES)) u_lanes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .n_lanes_i (n_lanes),
    .rdata_o   (rdata_o),
    .word_o    (word),
    .wr_ok_o   (wr_ok),
    .hi_wr_o   (hi_wr)
  );

  ser_tx_shift #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .word_i      (word),
    .nbits_i     (nbits),
    .half_i      (div_i),
    .busy_o      (busy),
    .frame_end_o (frame_end),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tde_q     <= 1'b1;
      tend_q    <= 1'b1;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= (n_lanes == 3'd0);
      if (hi_wr)     tde_q <= 1'b0;
      else if (load) tde_q <= 1'b1;
      if (wr_ok)                   tend_q <= 1'b0;
      else if (frame_end && tde_q) tend_q <= 1'b1;
    end
  end

  assign tde_o     = tde_q;
  assign tend_o    = tend_q;
  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/ser_tx_sva.sv
module ser_tx_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [1:0] len_i,
  input logic       sclk_o,
  input logic       sdo_o,
  input logic       tde_o,
  input logic       tend_o,
  input logic       busy_i
);
  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!sclk_o && !sdo_o)) else $error("idle lines");  // R7

  AST_SDO_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)) else $error("sdo moved");  // R8

  AST_TDE_CLR_HI_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && len_i == 2'b00 && addr_i == 2'b00) |-> !tde_o) else $error("tde");  // R4

  AST_TEND_CLR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && len_i != 2'b11 && addr_i == 2'b00) |-> !tend_o) else $error("tend clr");  // R10

  AST_TEND_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> !busy_i) else $error("tend busy");  // R10

  AST_RSVD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_i) && $past(len_i) == 2'b11) |-> !busy_i) else $error("rsvd start");  // R11

  AST_RSVD_TDE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(len_i) == 2'b11) |-> $stable(tde_o)) else $error("rsvd write");  // R11
endmodule

bind ser_tx_buf ser_tx_sva u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .len_i   (len_i),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o),
  .tde_o   (tde_o),
  .tend_o  (tend_o),
  .busy_i  (busy)
);

// File: tb/ser_tx_buf_test.sv
`timescale 1ns/1ps
module ser_tx_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] len = 2'b00;
  logic [7:0] div = 8'd1;
  logic       sclk, sdo, tde, tend, cfg_err;

  int n_cmp = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  ser_tx_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .len_i(len), .div_i(div), .sclk_o(sclk), .sdo_o(sdo),
    .tde_o(tde), .tend_o(tend), .cfg_err_o(cfg_err)
  );

  // line monitor: capture on sclk rise, flag sdo movement while high
  logic cap [128];
  int   rise_t [128];
  int   ncap = 0;
  int   cyc = 0;
  int   hold_bad = 0;
  logic sclk_p = 1'b0;
  logic sdo_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_p && ncap < 128) begin
      cap[ncap] = sdo;
      rise_t[ncap] = cyc;
      ncap++;
    end
    if (sclk && sclk_p && sdo !== sdo_p) hold_bad++;
    sclk_p = sclk;
    sdo_p = sdo;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_tend();
    int t = 0;
    while (!tend && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] got_word(int nb);
    logic [31:0] w = '0;
    for (int i = 0; i < nb; i++) w = {w[30:0], cap[i]};
    return w;
  endfunction

  function automatic int bad_gaps(int per);
    int b = 0;
    for (int i = 1; i < ncap; i++) if (rise_t[i] - rise_t[i-1] != per) b++;
    return b;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "tde", tde, 1);
    chk("R1", "tend", tend, 1);
    chk("R1", "cfg_err", cfg_err, 0);
    chk("R1", "sclk/sdo", {sclk, sdo}, 0);
    len = 2'b10;
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], d);
      chk("R1", "lane reset", d, 0);
    end
    len = 2'b00;
  endtask

  task automatic t_invalid_lane();
    logic [7:0] d;
    len = 2'b00;
    wr(2'd1, 8'h55);
    chk("R3", "tde after invalid write", tde, 1);
    chk("R3", "tend after invalid write", tend, 1);
    rd(2'd1, d);
    chk("R3", "invalid lane reads 0", d, 0);
    len = 2'b01;
    rd(2'd1, d);
    chk("R3", "ignored write not stored", d, 0);
    len = 2'b00;
  endtask

  task automatic t_len8();
    div = 8'd1; len = 2'b00; ncap = 0; hold_bad = 0;
    wr(2'd0, 8'hA5);
    chk("R4", "tde cleared by top lane", tde, 0);
    chk("R10", "tend cleared by write", tend, 0);
    @(negedge clk);
    chk("R5", "tde set on load", tde, 1);
    wait_tend();
    chk("R2", "8-bit count", ncap, 8);
    chk("R6", "8-bit data", got_word(8), 32'hA5);
    chk("R10", "tend at end", tend, 1);
    chk("R8", "sdo stable while sclk high", hold_bad, 0);
  endtask

  task automatic t_len16();
    logic [7:0] d;
    div = 8'd2; len = 2'b01; ncap = 0;
    wr(2'd0, 8'h34);
    chk("R4", "lower lane keeps tde", tde, 1);
    wr(2'd1, 8'h12);
    chk("R4", "top lane clears tde", tde, 0);
    wait_tend();
    chk("R2", "16-bit count", ncap, 16);
    chk("R6", "16-bit order", got_word(16), 32'h1234);
    chk("R7", "period 2N, N=2", bad_gaps(4), 0);
    rd(2'd1, d);
    chk("R3", "read lane1", d, 8'h12);
  endtask

  task automatic t_len32();
    div = 8'd3; len = 2'b10; ncap = 0; hold_bad = 0;
    wr(2'd0, 8'hEF); wr(2'd1, 8'hBE); wr(2'd2, 8'hAD);
    chk("R4", "tde held before top lane", tde, 1);
    wr(2'd3, 8'hDE);
    wait_tend();
    chk("R2", "32-bit count", ncap, 32);
    chk("R6", "32-bit order", got_word(32), 32'hDEADBEEF);
    chk("R7", "period 2N, N=3", bad_gaps(6), 0);
    chk("R8", "sdo stable 32", hold_bad, 0);
  endtask

  task automatic t_b2b();
    int t = 0;
    int tend_seen = 0;
    div = 8'd2; len = 2'b01; ncap = 0;
    wr(2'd0, 8'hC3); wr(2'd1, 8'h81);
    while (!tde && t < 100) begin @(negedge clk); t++; end
    wr(2'd0, 8'h0F); wr(2'd1, 8'h7E);
    t = 0;
    while (ncap < 32 && t < 2000) begin
      @(negedge clk);
      if (tend && ncap < 32) tend_seen++;
      t++;
    end
    wait_tend();
    chk("R9", "two frames bits", ncap, 32);
    chk("R9", "two frames data", got_word(32), 32'h81C37E0F);
    chk("R9", "no gap between frames", bad_gaps(4), 0);
    chk("R10", "tend low between frames", tend_seen, 0);
  endtask

  task automatic t_rsvd();
    logic [7:0] d;
    div = 8'd1; len = 2'b00;
    wr(2'd0, 8'h3C);
    wait_tend();
    ncap = 0;
    len = 2'b11;
    @(negedge clk);
    chk("R11", "cfg_err set", cfg_err, 1);
    wr(2'd0, 8'h77);
    chk("R11", "tde unchanged", tde, 1);
    rd(2'd0, d);
    chk("R3", "reserved read 0", d, 0);
    repeat (40) @(negedge clk);
    chk("R11", "no frame", ncap, 0);
    chk("R11", "cfg_err held", cfg_err, 1);
    len = 2'b00;
    @(negedge clk);
    chk("R11", "cfg_err cleared", cfg_err, 0);
    rd(2'd0, d);
    chk("R11", "lane kept", d, 8'h3C);
    repeat (20) @(negedge clk);
    chk("R11", "no late frame", ncap, 0);
  endtask

  task automatic t_div0();
    div = 8'd0; len = 2'b00; ncap = 0;
    wr(2'd0, 8'h96);
    wait_tend();
    chk("R7", "div0 data", got_word(8), 32'h96);
    chk("R7", "div0 acts as 1", bad_gaps(2), 0);
    chk("R7", "sclk idle low", sclk, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid_lane();
    t_len8();
    t_len16();
    t_len32();
    t_b2b();
    t_rsvd();
    t_div0();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule